// File: doc/BRIEF.md
# Page-Switched ROM Controller

This block is a read-only memory window placed in a 16-bit word address space that is cut into sixteen 4K-word ranges, selected by address bits [15:12]. Each range holds a live page number. The ROM answers a read only when the live page of the addressed range equals the page the ROM was built for, and only for ranges that the ROM image actually spans. In every other case the bus sees all ones and the hit flag stays low.

Software changes the live page with an unlock write. The write must land on the last word of a range (offset 0xFFF), and its data must agree with a masked copy of its own address. When the write is accepted, the block updates the page of the range named by the data and sends a one-cycle pulse naming the 4K span that any cached copy of that range must drop. A separate debug port loads the ROM image, and it only reaches words whose range currently shows the ROM's page. Bus writes never change the ROM contents.

Top module: `pgrom_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets the live page of all sixteen ranges to 0 and clears the invalidate pulse. With the default ROM page of 3, a read right after reset misses.
- R2: A read whose address lies inside the ROM image, and whose range shows the ROM page, returns the stored word at (address - ROM_BASE) on cpu_rdata and raises cpu_hit, both in the same cycle as the address.
- R3: A read of a covered range whose live page differs from the ROM page returns 16'hFFFF with cpu_hit low.
- R4: A bus write is taken as a page select only if address[11:0] is 12'hFFF and (address & 16'hFA50) equals (data & 16'hFFF0). Any other write leaves every live page unchanged and produces no invalidate pulse.
- R5: An accepted page select sets the live page of range data[15:12] to data[3:0]. The new page governs reads from the next clock cycle on, and other ranges keep their pages.
- R6: On the rising edge that takes an accepted page select, inv_valid rises for one cycle with inv_start = range<<12 and inv_end = (range<<12)|16'h0FFF.
- R7: A debug poke stores dbg_wdata at (dbg_addr - ROM_BASE) only when dbg_addr lies inside the ROM image and its range shows the ROM page. Otherwise the poke is dropped.
- R8: Stored words are DATA_W bits wide, and on a hit cpu_rdata carries the word zero-extended to 16 bits.
- R9: Bus writes never alter ROM contents.
- R10: Reads of addresses outside the ROM image return 16'hFFFF with cpu_hit low. This covers the unused tail of a covered range and ranges the ROM does not span, whatever their live page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Bus word address for reads and writes |
| cpu_wdata | input | 16 | Bus write data |
| cpu_we | input | 1 | Bus write strobe |
| cpu_rdata | output | 16 | Read data: ROM word on a hit, all ones otherwise |
| cpu_hit | output | 1 | High when this ROM answers the current address |
| dbg_we | input | 1 | Debug poke strobe |
| dbg_addr | input | 16 | Debug poke word address |
| dbg_wdata | input | DATA_W | Debug poke data |
| inv_valid | output | 1 | One-cycle invalidate request |
| inv_start | output | 16 | First address of the span to invalidate |
| inv_end | output | 16 | Last address of the span to invalidate |

## Verification
Read results are combinational. The bench drives the address on a falling edge and samples one nanosecond later, within the same cycle. A page select or a poke takes effect at the next rising edge, so the bench holds the strobe for one cycle and makes its follow-up read in the next cycle. The invalidate pulse is checked at the falling edge that follows the accepting rising edge, and checked low again one cycle later. Writes that must be ignored are tested through later reads and through the absence of a pulse, never through internal state.

// File: rtl/pgrom_pkg.sv
// Package: shared constants and types for the page-switched ROM controller.
// Assumes a 16-bit word address space split into sixteen 4K-word ranges.
package pgrom_pkg;

    localparam int BUS_W      = 16;
    localparam int RANGE_BITS = 4;
    localparam int NUM_RANGES = 1 << RANGE_BITS;
    localparam int OFFS_W     = BUS_W - RANGE_BITS;
    localparam int PAGE_W     = 4;

    localparam logic [BUS_W-1:0]  ADDR_KEY_MASK = 16'hFA50;
    localparam logic [BUS_W-1:0]  DATA_KEY_MASK = 16'hFFF0;
    localparam logic [OFFS_W-1:0] LAST_OFFSET   = '1;

    typedef logic [RANGE_BITS-1:0] range_t;
    typedef logic [PAGE_W-1:0]     page_t;

    typedef struct packed {
        logic [BUS_W-1:0] first;
        logic [BUS_W-1:0] last;
    } span_t;

endpackage

// File: rtl/pgrom_unlock.sv
// Module: pgrom_unlock
// Decodes the page-select unlock write and registers the invalidate request.
// Assumes cpu_we is a one-cycle-per-access strobe sampled on the rising edge.
module pgrom_unlock
    import pgrom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    output logic             sel_en,
    output range_t           sel_range,
    output page_t            sel_page,
    output logic             inv_valid,
    output span_t            inv_span
);

    logic key_ok;
    span_t span_d;

    // Unlock check: last word of a range and the address/data key agree.
    always_comb begin
        key_ok    = (wr_addr[OFFS_W-1:0] == LAST_OFFSET) &&
                    ((wr_addr & ADDR_KEY_MASK) == (wr_data & DATA_KEY_MASK));
        sel_en    = wr_en && key_ok;
        sel_range = wr_data[BUS_W-1:OFFS_W];
        sel_page  = wr_data[PAGE_W-1:0];
        span_d.first = {sel_range, {OFFS_W{1'b0}}};
        span_d.last  = {sel_range, {OFFS_W{1'b1}}};
    end

    // Invalidate register: one-cycle pulse carrying the selected span.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid <= 1'b0;
            inv_span  <= '0;
        end else begin
            inv_valid <= sel_en;
            if (sel_en) begin
                inv_span <= span_d;
            end
        end
    end

    p_inv_after_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(sel_en));

    p_inv_follows_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |=> inv_valid);

endmodule

// File: rtl/pgrom_page_table.sv
// Module: pgrom_page_table
// Holds the live page of each of the sixteen ranges and flags the ranges
// whose live page equals the ROM page. Only ranges the image spans can match.
// Assumes ROM_BASE is aligned to the image size.
module pgrom_page_table
    import pgrom_pkg::*;
#(
    parameter logic [BUS_W-1:0] ROM_BASE = 16'h2000,
    parameter int               ROM_AW   = 11,
    parameter logic [PAGE_W-1:0] ROM_PAGE = 4'd3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_en,
    input  range_t                sel_range,
    input  page_t                 sel_page,
    output logic [NUM_RANGES-1:0] match
);

    localparam int ROM_WORDS = 1 << ROM_AW;
    localparam int LO_RANGE  = int'(ROM_BASE) >> OFFS_W;
    localparam int HI_RANGE  = (int'(ROM_BASE) + ROM_WORDS - 1) >> OFFS_W;

    page_t page_q [NUM_RANGES];

    for (genvar r = 0; r < NUM_RANGES; r++) begin : g_range
        localparam bit COVERS = (r >= LO_RANGE) && (r <= HI_RANGE);

        // Live page register for this range: cleared by reset, set by select.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_q[r] <= '0;
            end else if (sel_en && (sel_range == range_t'(r))) begin
                page_q[r] <= sel_page;
            end
        end

        // Match flag: covered range showing the ROM page.
        always_comb begin
            match[r] = COVERS && (page_q[r] == ROM_PAGE);
        end

        p_reset_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (page_q[r] == '0));

        p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel_en && (sel_range == range_t'(r))) |=> $stable(page_q[r]));
    end

    p_sel_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |=> (page_q[$past(sel_range)] == $past(sel_page)));

endmodule

// File: rtl/pgrom_store.sv
// Module: pgrom_store
// ROM image storage: asynchronous read port for the bus, write port for the
// debug poke. Assumes ROM_BASE is aligned to 2**ROM_AW words.
module pgrom_store
    import pgrom_pkg::*;
#(
    parameter int               DATA_W   = 10,
    parameter logic [BUS_W-1:0] ROM_BASE = 16'h2000,
    parameter int               ROM_AW   = 11
) (
    input  logic              clk,
    input  logic [BUS_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_in_win,
    input  logic              pk_req,
    input  logic [BUS_W-1:0]  pk_addr,
    input  logic [DATA_W-1:0] pk_data
);

    localparam int ROM_WORDS = 1 << ROM_AW;
    localparam int TAG_W     = BUS_W - ROM_AW;
    localparam logic [TAG_W-1:0] WIN_TAG = ROM_BASE[BUS_W-1:ROM_AW];

    logic [DATA_W-1:0] image [ROM_WORDS];
    logic              pk_in_win;

    // Window decode for both ports.
    always_comb begin
        rd_in_win = (rd_addr[BUS_W-1:ROM_AW] == WIN_TAG);
        pk_in_win = (pk_addr[BUS_W-1:ROM_AW] == WIN_TAG);
        rd_word   = image[rd_addr[ROM_AW-1:0]];
    end

    // Image write: accepted pokes that land inside the window.
    always_ff @(posedge clk) begin
        if (pk_req && pk_in_win) begin
            image[pk_addr[ROM_AW-1:0]] <= pk_data;
        end
    end

endmodule

// File: rtl/pgrom_ctrl.sv
// Module: pgrom_ctrl (top)
// Page-switched ROM window: bus reads answer only when the addressed range
// shows the ROM page, unlock writes change range pages and request cache
// invalidation, and a debug port loads the image under the same page rule.
// Assumes ROM_BASE aligned to 2**ROM_AW and 1 <= DATA_W <= 16.
module pgrom_ctrl
    import pgrom_pkg::*;
#(
    parameter int               DATA_W   = 10,
    parameter logic [15:0]      ROM_BASE = 16'h2000,
    parameter int               ROM_AW   = 11,
    parameter logic [3:0]       ROM_PAGE = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [15:0]       cpu_wdata,
    input  logic              cpu_we,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_hit,
    input  logic              dbg_we,
    input  logic [15:0]       dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic              inv_valid,
    output logic [15:0]       inv_start,
    output logic [15:0]       inv_end
);

    logic                  sel_en;
    range_t                sel_range;
    page_t                 sel_page;
    span_t                 inv_span;
    logic [NUM_RANGES-1:0] match;
    logic [DATA_W-1:0]     rd_word;
    logic                  rd_in_win;
    logic                  pk_req;

    pgrom_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_we),
        .wr_addr   (cpu_addr),
        .wr_data   (cpu_wdata),
        .sel_en    (sel_en),
        .sel_range (sel_range),
        .sel_page  (sel_page),
        .inv_valid (inv_valid),
        .inv_span  (inv_span)
    );

    pgrom_page_table #(
        .ROM_BASE (ROM_BASE),
        .ROM_AW   (ROM_AW),
        .ROM_PAGE (ROM_PAGE)
    ) u_pages (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_en    (sel_en),
        .sel_range (sel_range),
        .sel_page  (sel_page),
        .match     (match)
    );

    pgrom_store #(
        .DATA_W   (DATA_W),
        .ROM_BASE (ROM_BASE),
        .ROM_AW   (ROM_AW)
    ) u_store (
        .clk       (clk),
        .rd_addr   (cpu_addr),
        .rd_word   (rd_word),
        .rd_in_win (rd_in_win),
        .pk_req    (pk_req),
        .pk_addr   (dbg_addr),
        .pk_data   (dbg_wdata)
    );

    // Read mux and poke gate: both follow the page match of their range.
    always_comb begin
        cpu_hit   = rd_in_win && match[cpu_addr[15:12]];
        cpu_rdata = cpu_hit ? 16'(rd_word) : 16'hFFFF;
        pk_req    = dbg_we && match[dbg_addr[15:12]];
        inv_start = inv_span.first;
        inv_end   = inv_span.last;
    end

    p_inv_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_start[11:0] == 12'h000) &&
                       (inv_end == (inv_start | 16'h0FFF))));

    p_hit_needs_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> match[cpu_addr[15:12]]);

    if (DATA_W < 16) begin : g_mask_chk
        p_hit_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_hit |-> (cpu_rdata[15:DATA_W] == '0));
    end

endmodule

// File: tb/pgrom_ctrl_tb.sv
// Bench: directed scenarios for pgrom_ctrl, one task per scenario.
module pgrom_ctrl_tb_top;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [15:0]   cpu_wdata = '0;
    logic          cpu_we = 1'b0;
    logic [15:0]   cpu_rdata;
    logic          cpu_hit;
    logic          dbg_we = 1'b0;
    logic [15:0]   dbg_addr = '0;
    logic [DW-1:0] dbg_wdata = '0;
    logic          inv_valid;
    logic [15:0]   inv_start;
    logic [15:0]   inv_end;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pgrom_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .cpu_rdata (cpu_rdata),
        .cpu_hit   (cpu_hit),
        .dbg_we    (dbg_we),
        .dbg_addr  (dbg_addr),
        .dbg_wdata (dbg_wdata),
        .inv_valid (inv_valid),
        .inv_start (inv_start),
        .inv_end   (inv_end)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Bus write held for one cycle; its effect is visible at the return point.
    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic poke(input logic [15:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    // Read: combinational, sampled 1 ns after the address changes.
    task automatic read_chk(input string tag, input logic [15:0] a,
                            input logic [15:0] exp_d, input logic exp_h);
        @(negedge clk);
        cpu_addr = a;
        #1;
        check({tag, " data"}, cpu_rdata, exp_d);
        check({tag, " hit"}, {15'b0, cpu_hit}, {15'b0, exp_h});
    endtask

    task automatic t_reset_state;
        check("R1 inv_valid after reset", {15'b0, inv_valid}, 16'h0);
        read_chk("R1 read after reset", 16'h2000, 16'hFFFF, 1'b0);
    endtask

    task automatic t_select_and_pulse;
        bus_write(16'h2FFF, 16'h2A53);
        check("R6 pulse valid", {15'b0, inv_valid}, 16'h1);
        check("R6 pulse start", inv_start, 16'h2000);
        check("R6 pulse end", inv_end, 16'h2FFF);
        @(negedge clk);
        check("R6 pulse one cycle", {15'b0, inv_valid}, 16'h0);
    endtask

    task automatic t_poke_and_read;
        poke(16'h2000, 10'h155);
        poke(16'h27FF, 10'h2AA);
        poke(16'h2010, 10'h3FF);
        read_chk("R2 first word", 16'h2000, 16'h0155, 1'b1);
        read_chk("R2 last word", 16'h27FF, 16'h02AA, 1'b1);
        read_chk("R8 zero extend", 16'h2010, 16'h03FF, 1'b1);
    endtask

    task automatic t_poke_blocked;
        bus_write(16'h2FFF, 16'h2A50);              // R5: range 2 to page 0
        read_chk("R3 page 0 miss", 16'h2000, 16'hFFFF, 1'b0);
        poke(16'h2000, 10'h0AB);                    // R7: dropped
        bus_write(16'h2FFF, 16'h2A53);
        read_chk("R7 poke dropped", 16'h2000, 16'h0155, 1'b1);
    endtask

    task automatic t_reject_writes;
        bus_write(16'h2FFE, 16'h2A54);              // offset not 0xFFF
        check("R4 no pulse offset", {15'b0, inv_valid}, 16'h0);
        read_chk("R4 page kept offset", 16'h2000, 16'h0155, 1'b1);
        bus_write(16'h2FFF, 16'h2B54);              // key mismatch
        check("R4 no pulse key", {15'b0, inv_valid}, 16'h0);
        read_chk("R4 page kept key", 16'h2000, 16'h0155, 1'b1);
        bus_write(16'h2000, 16'hFFFF);
        read_chk("R9 bus write no effect", 16'h2000, 16'h0155, 1'b1);
    endtask

    task automatic t_switch_away;
        bus_write(16'h2FFF, 16'h2A54);
        read_chk("R3 page 4 miss", 16'h27FF, 16'hFFFF, 1'b0);
        bus_write(16'h2FFF, 16'h2A53);
        read_chk("R5 back to page 3", 16'h27FF, 16'h02AA, 1'b1);
    endtask

    task automatic t_outside;
        read_chk("R10 range tail", 16'h2800, 16'hFFFF, 1'b0);
        bus_write(16'h5FFF, 16'h5A53);
        check("R6 range 5 start", inv_start, 16'h5000);
        check("R6 range 5 end", inv_end, 16'h5FFF);
        read_chk("R10 uncovered range", 16'h5000, 16'hFFFF, 1'b0);
        read_chk("R5 other range kept", 16'h2000, 16'h0155, 1'b1);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_chk("R1 reset clears page", 16'h2000, 16'hFFFF, 1'b0);
        check("R1 no pulse after reset", {15'b0, inv_valid}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_select_and_pulse();
        t_poke_and_read();
        t_poke_blocked();
        t_reject_writes();
        t_switch_away();
        t_outside();
        t_reset_again();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule